// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the cycle-exact timeline of a single analog-to-digital conversion, clocked by the bus clock. A free-running divider derives a converter-clock enable from the bus clock at a ratio of 1, 2, 4 or 8. When a start pulse arrives and the block is idle, it steps through four stages: a bus-clock setup, a converter-clock setup, a sample stage and a convert stage. It then raises a one-cycle done strobe. The sample and convert stages are flagged on their own outputs so that analog front-end control can follow them.

The lengths of the stages depend on the resolution, on an optional extended sample window and on a high-speed adder. All three are taken from the inputs in the cycle the start pulse is accepted and are held for the whole conversion. A behavioural stand-in produces a result word in the same cycle the done strobe rises. The word follows a fixed arithmetic pattern and is masked to the selected resolution, so that logic further on can be tested without an analog model. Averaging over several conversions is left to a separate block, which sees each conversion as one done strobe.

Top module: `adc_conv_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, sampling, converting, done and result are all 0.
- R2: adck_en is a one-cycle pulse that repeats every 2^div_sel bus cycles. div_sel 0, 1, 2 and 3 give ratios of 1, 2, 4 and 8.
- R3: A start pulse seen while idle sets busy in the next cycle. busy stays high through the cycle in which done is high and is low in the cycle after it.
- R4: Each conversion first spends 5 bus cycles in setup and then 5 further adck_en pulses, before sampling rises.
- R5: The sample stage lasts 3 adck_en pulses, plus 2 when hs_en is 1, plus an extra window when lsamp_en is 1. lsamp_sel 0, 1, 2 and 3 select an extra 2, 6, 12 and 20 pulses. At ratio 1 or 4 the stage covers that many pulses times the ratio in bus cycles.
- R6: The convert stage lasts the base count minus 3 adck_en pulses. The base count is 17, 20, 22 or 26 for res_sel 0, 1, 2 and 3, which select 8, 10, 12 and 16 bits. done rises in the cycle after the last convert pulse.
- R7: At ratio 1, with 8-bit resolution, high speed on and no extended sample, busy is high for exactly 29 cycles before the done cycle.
- R8: A start pulse that arrives while busy is ignored: the conversion in progress keeps its timing and does not restart.
- R9: Changes to res_sel, hs_en, lsamp_en and lsamp_sel during a conversion do not affect that conversion.
- R10: result changes only in a done cycle. For the n-th conversion since reset (n from 0) it holds (0x2A5C + n*0x1357) mod 2^16, ANDed with a mask of the low 8, 10, 12 or 16 bits as chosen by the captured res_sel.
- R11: sampling and converting are never high together, and done is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Converter-clock divide select (ratio 2^div_sel) |
| start | input | 1 | Start pulse, acted on only while idle |
| res_sel | input | 2 | Resolution: 0=8, 1=10, 2=12, 3=16 bits |
| lsamp_en | input | 1 | Extended sample window enable |
| lsamp_sel | input | 2 | Extended window: 0=2, 1=6, 2=12, 3=20 converter cycles |
| hs_en | input | 1 | High-speed adder enable (+2 converter cycles) |
| adck_en | output | 1 | Converter-clock enable pulse |
| busy | output | 1 | Conversion in progress, including the done cycle |
| sampling | output | 1 | Sample stage active |
| converting | output | 1 | Convert stage active |
| done | output | 1 | One-cycle conversion-complete strobe |
| result | output | 16 | Stand-in result word, updated with done |

## Verification
Conversions at ratio 1 are run for every resolution, with high speed on and off and with several extended sample windows. The measured cycle counts of the setup, sample and convert stages separate mistakes in the base lookup from mistakes in the adders and in the fixed setup overhead. A run at ratio 4 shows whether the sample and convert stages advance only on converter-clock enables, while the separate divider period measurements expose a wrong ratio decode. One conversion is disturbed by a second start pulse and by flipped mode inputs part way through; its unchanged stage lengths and unchanged result mask show that the mode is captured at the start and that the extra start pulse is ignored.

// File: rtl/adct_pkg.sv
package adct_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SBUS,
    PH_SADCK,
    PH_SAMP,
    PH_CONV,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic [1:0] res;
    logic       lsamp;
    logic [1:0] lsel;
    logic       hs;
  } cfg_t;

  // Base converter-cycle count per resolution code.
  function automatic int base_cycles(input logic [1:0] res);
    case (res)
      2'd0:    return 17;
      2'd1:    return 20;
      2'd2:    return 22;
      default: return 26;
    endcase
  endfunction

  // Extended sample window per select code.
  function automatic int lst_extra(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 6;
      2'd2:    return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int res_bits(input logic [1:0] res);
    case (res)
      2'd0:    return 8;
      2'd1:    return 10;
      2'd2:    return 12;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/adct_clkdiv.sv
module adct_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int MAX_RATIO = 1 << ((1 << DIV_W) - 1);
  localparam int CW        = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'((32'd1 << div_sel) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adct_len_calc.sv
module adct_len_calc
  import adct_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int SMP_BASE = 3,
  parameter int HS_ADD   = 2
) (
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] smp_len,
  output logic [CNT_W-1:0] cnv_len
);
  int smp_i;
  int cnv_i;

  always_comb begin
    smp_i = SMP_BASE;
    if (cfg.hs)    smp_i = smp_i + HS_ADD;
    if (cfg.lsamp) smp_i = smp_i + lst_extra(cfg.lsel);
    cnv_i   = base_cycles(cfg.res) - SMP_BASE;
    smp_len = CNT_W'(smp_i);
    cnv_len = CNT_W'(cnv_i);
  end
endmodule

// File: rtl/adct_seq.sv
module adct_seq
  import adct_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int SETUP_BUS  = 5,
  parameter int SETUP_ADCK = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adck_en,
  input  logic [CNT_W-1:0] smp_len,
  input  logic [CNT_W-1:0] cnv_len,
  output logic             accept,
  output logic             finish,
  output logic             busy,
  output logic             sampling,
  output logic             converting,
  output logic             done
);
  phase_t           st, nst;
  logic [CNT_W-1:0] cnt, ncnt;

  assign accept = (st == PH_IDLE) && start;
  assign finish = (st == PH_CONV) && adck_en && (cnt == '0);

  always_comb begin
    nst  = st;
    ncnt = cnt;
    case (st)
      PH_IDLE: if (start) begin
        nst  = PH_SBUS;
        ncnt = CNT_W'(SETUP_BUS - 1);
      end
      PH_SBUS: begin
        if (cnt == '0) begin
          nst  = PH_SADCK;
          ncnt = CNT_W'(SETUP_ADCK - 1);
        end else begin
          ncnt = cnt - 1'b1;
        end
      end
      PH_SADCK: if (adck_en) begin
        if (cnt == '0) begin
          nst  = PH_SAMP;
          ncnt = smp_len - 1'b1;
        end else begin
          ncnt = cnt - 1'b1;
        end
      end
      PH_SAMP: if (adck_en) begin
        if (cnt == '0) begin
          nst  = PH_CONV;
          ncnt = cnv_len - 1'b1;
        end else begin
          ncnt = cnt - 1'b1;
        end
      end
      PH_CONV: if (adck_en) begin
        if (cnt == '0) begin
          nst  = PH_DONE;
          ncnt = '0;
        end else begin
          ncnt = cnt - 1'b1;
        end
      end
      default: begin
        nst  = PH_IDLE;
        ncnt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      cnt        <= '0;
      busy       <= 1'b0;
      sampling   <= 1'b0;
      converting <= 1'b0;
      done       <= 1'b0;
    end else begin
      st         <= nst;
      cnt        <= ncnt;
      busy       <= (nst != PH_IDLE);
      sampling   <= (nst == PH_SAMP);
      converting <= (nst == PH_CONV);
      done       <= (nst == PH_DONE);
    end
  end
endmodule

// File: rtl/adct_result_model.sv
module adct_result_model
  import adct_pkg::*;
#(
  parameter int               RES_W = 16,
  parameter logic [RES_W-1:0] SEED  = 16'h2A5C,
  parameter logic [RES_W-1:0] STEP  = 16'h1357
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [1:0]       res,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] mask;

  always_comb mask = RES_W'((32'd1 << res_bits(res)) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= SEED;
      result <= '0;
    end else if (fire) begin
      result <= acc & mask;
      acc    <= acc + STEP;
    end
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adct_pkg::*;
#(
  parameter int               DIV_W      = 2,
  parameter int               CNT_W      = 6,
  parameter int               SETUP_BUS  = 5,
  parameter int               SETUP_ADCK = 5,
  parameter int               SMP_BASE   = 3,
  parameter int               HS_ADD     = 2,
  parameter int               RES_W      = 16,
  parameter logic [RES_W-1:0] SEED       = 16'h2A5C,
  parameter logic [RES_W-1:0] STEP       = 16'h1357
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             start,
  input  logic [1:0]       res_sel,
  input  logic             lsamp_en,
  input  logic [1:0]       lsamp_sel,
  input  logic             hs_en,
  output logic             adck_en,
  output logic             busy,
  output logic             sampling,
  output logic             converting,
  output logic             done,
  output logic [RES_W-1:0] result
);
  cfg_t             cfg_q;
  logic             accept;
  logic             finish;
  logic [CNT_W-1:0] smp_len;
  logic [CNT_W-1:0] cnv_len;

  // Mode is frozen when a start is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q <= '{res: res_sel, lsamp: lsamp_en, lsel: lsamp_sel, hs: hs_en};
    end
  end

  adct_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .div_sel (div_sel),
    .tick    (adck_en)
  );

  adct_len_calc #(
    .CNT_W    (CNT_W),
    .SMP_BASE (SMP_BASE),
    .HS_ADD   (HS_ADD)
  ) u_len (
    .cfg     (cfg_q),
    .smp_len (smp_len),
    .cnv_len (cnv_len)
  );

  adct_seq #(
    .CNT_W      (CNT_W),
    .SETUP_BUS  (SETUP_BUS),
    .SETUP_ADCK (SETUP_ADCK)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .adck_en    (adck_en),
    .smp_len    (smp_len),
    .cnv_len    (cnv_len),
    .accept     (accept),
    .finish     (finish),
    .busy       (busy),
    .sampling   (sampling),
    .converting (converting),
    .done       (done)
  );

  adct_result_model #(
    .RES_W (RES_W),
    .SEED  (SEED),
    .STEP  (STEP)
  ) u_res (
    .clk    (clk),
    .rst    (rst),
    .fire   (finish),
    .res    (cfg_q.res),
    .result (result)
  );
endmodule

// File: rtl/adct_checker.sv
module adct_checker #(
  parameter int DIV_W = 2,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [DIV_W-1:0] div_sel,
  input logic             adck_en,
  input logic             busy,
  input logic             sampling,
  input logic             converting,
  input logic             done,
  input logic [RES_W-1:0] result
);
  p_div_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (adck_en && div_sel != '0) |=> !adck_en);

  p_busy_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));

  p_done_busy_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  p_sample_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sampling) |-> $past(adck_en));

  p_done_entry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(converting) && $past(adck_en)));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && start) |=> busy);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  p_phase_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(sampling && converting));

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind adc_conv_timer adct_checker #(.DIV_W(DIV_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .div_sel    (div_sel),
  .adck_en    (adck_en),
  .busy       (busy),
  .sampling   (sampling),
  .converting (converting),
  .done       (done),
  .result     (result)
);

// File: tb/adc_conv_timer_test.sv
module adc_conv_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEED_V = 16'h2A5C;
  localparam int STEP_V = 16'h1357;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  div_sel = 2'd0;
  logic        start = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic        lsamp_en = 1'b0;
  logic [1:0]  lsamp_sel = 2'd0;
  logic        hs_en = 1'b0;
  logic        adck_en, busy, sampling, converting, done;
  logic [15:0] result;

  int nchk = 0;
  int nfail = 0;
  int nconv = 0;
  int cyc = 0;
  bit finished = 0;
  bit model_on = 0;

  adc_conv_timer uut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .start(start),
    .res_sel(res_sel), .lsamp_en(lsamp_en), .lsamp_sel(lsamp_sel),
    .hs_en(hs_en), .adck_en(adck_en), .busy(busy), .sampling(sampling),
    .converting(converting), .done(done), .result(result)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int f_base(input int r);
    int t[4] = '{17, 20, 22, 26};
    return t[r];
  endfunction
  function automatic int f_lx(input int s);
    int t[4] = '{2, 6, 12, 20};
    return t[s];
  endfunction
  function automatic int f_mask(input int r);
    int t[4] = '{8, 10, 12, 16};
    return (1 << t[r]) - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // Behavioural reference: phase number and cycles left in it.
  int m_ph = 0, m_left = 0, m_dcnt = 0, m_en = 0, m_acc = SEED_V, m_res = 0;
  int m_slen = 0, m_clen = 0, m_r = 0;

  always @(posedge clk) begin
    int en_now;
    int ratio;
    cyc++;
    if (rst) begin
      m_ph = 0; m_left = 0; m_dcnt = 0; m_en = 0; m_acc = SEED_V; m_res = 0;
    end else begin
      en_now = m_en;
      ratio = 1 << div_sel;
      if (m_dcnt >= ratio - 1) begin m_dcnt = 0; m_en = 1; end
      else begin m_dcnt++; m_en = 0; end
      case (m_ph)
        0: if (start) begin
          m_ph = 1; m_left = 5; m_r = res_sel;
          m_slen = 3 + (hs_en ? 2 : 0) + (lsamp_en ? f_lx(lsamp_sel) : 0);
          m_clen = f_base(res_sel) - 3;
        end
        1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = 5; end end
        2: if (en_now != 0) begin m_left--; if (m_left == 0) begin m_ph = 3; m_left = m_slen; end end
        3: if (en_now != 0) begin m_left--; if (m_left == 0) begin m_ph = 4; m_left = m_clen; end end
        4: if (en_now != 0) begin
          m_left--;
          if (m_left == 0) begin
            m_ph = 5;
            m_res = m_acc & f_mask(m_r);
            m_acc = (m_acc + STEP_V) & 16'hFFFF;
          end
        end
        default: m_ph = 0;
      endcase
    end
    if (cyc > 100000 && !finished) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R2 adck_en", int'(adck_en), m_en);
      chk("R3 busy", int'(busy), int'(m_ph != 0));
      chk("R5 sampling", int'(sampling), int'(m_ph == 3));
      chk("R6 converting", int'(converting), int'(m_ph == 4));
      chk("R11 done", int'(done), int'(m_ph == 5));
      chk("R10 result", int'(result), m_res);
    end
  end

  task automatic run_conv(input int dv, input int rs, input int le, input int ls,
                          input int h, input bit glitch, input int e_tot,
                          input int e_su, input int e_s, input int e_c);
    int tot = 0, su = 0, s = 0, c = 0, k = 0, exp_res;
    bit seen = 0;
    @(negedge clk);
    div_sel = 2'(dv); res_sel = 2'(rs); lsamp_en = le[0];
    lsamp_sel = 2'(ls); hs_en = h[0]; start = 1'b1;
    exp_res = ((SEED_V + nconv * STEP_V) & 16'hFFFF) & f_mask(rs);
    @(negedge clk);
    start = 1'b0;
    while (!seen && k < 5000) begin
      if (done) seen = 1;
      else if (busy) begin
        tot++;
        if (sampling) s++;
        else if (converting) c++;
        else su++;
      end
      // R8 and R9: extra start and flipped mode mid-conversion
      if (glitch && k == 7) begin
        start = 1'b1; res_sel = 2'(rs ^ 3); hs_en = !h[0];
        lsamp_en = !le[0]; lsamp_sel = 2'(ls ^ 1);
      end
      if (glitch && k == 8) start = 1'b0;
      if (glitch && k == 20) begin start = 1'b1; end
      if (glitch && k == 21) start = 1'b0;
      k++;
      if (!seen) @(negedge clk);
    end
    chk("R3 done reached", int'(seen), 1);
    chk("R10 result at done", int'(result), exp_res);
    if (e_tot >= 0) chk("R7 busy cycles", tot, e_tot);
    if (e_su >= 0)  chk("R4 setup cycles", su, e_su);
    chk("R5 sample cycles", s, e_s);
    chk("R6 convert cycles", c, e_c);
    if (glitch) chk("R9 mask kept", int'(result), exp_res);
    nconv++;
    @(negedge clk);
    chk("R3 busy low after done", int'(busy), 0);
    chk("R11 done single", int'(done), 0);
  endtask

  task automatic div_period(input int dv, input int exp);
    int gap = 0, k = 0;
    @(negedge clk);
    div_sel = 2'(dv);
    repeat (20) @(negedge clk);
    while (!adck_en && k < 100) begin k++; @(negedge clk); end
    @(negedge clk);
    gap = 1;
    while (!adck_en && gap < 100) begin gap++; @(negedge clk); end
    chk("R2 enable period", gap, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 result in reset", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sampling after reset", int'(sampling), 0);
    chk("R1 converting after reset", int'(converting), 0);
    chk("R1 busy after reset", int'(busy), 0);
    model_on = 1;
    repeat (3) @(negedge clk);
    // R7: 8-bit, high speed, ratio 1
    run_conv(0, 0, 0, 0, 1, 0, 29, 10, 5, 14);
    // R6: 16-bit with extended window code 2
    run_conv(0, 3, 1, 2, 0, 0, 48, 10, 15, 23);
    // 10-bit plain
    run_conv(0, 1, 0, 0, 0, 0, 30, 10, 3, 17);
    // R5: 8-bit, longest window, then shortest
    run_conv(0, 0, 1, 3, 0, 0, 47, 10, 23, 14);
    run_conv(0, 0, 1, 0, 0, 0, 29, 10, 5, 14);
    // R8 / R9: 12-bit, high speed, window code 1, disturbed
    run_conv(0, 2, 1, 1, 1, 1, 40, 10, 11, 19);
    // Ratio 4: stages scale by 4
    run_conv(2, 0, 0, 0, 1, 0, -1, -1, 20, 56);
    run_conv(2, 3, 1, 3, 1, 0, -1, -1, 100, 92);
    // Ratio 2 and 8 with model comparison
    run_conv(1, 1, 1, 2, 0, 0, -1, -1, 30, 34);
    run_conv(3, 2, 0, 0, 0, 0, -1, -1, 24, 152);
    div_period(3, 8);
    div_period(1, 2);
    div_period(2, 4);
    div_period(0, 1);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule